// File: doc/BRIEF.md
# Regulator Control Register Slave on a Two-Wire Serial Bus

This block lets a host on a two-wire serial bus set up a power-management die. It answers to one fixed 7-bit device address and holds seven 8-bit control registers. Two registers hold the step-down converter voltage codes, two hold the linear regulator voltage codes, one holds the converter options, one holds the system enables and the power-good delay, and one holds the converter slew rates. Every register is driven in parallel onto its own output bus, so the regulator logic sees a new setting as soon as the byte that carries it is acknowledged.

The bus lines come in as raw, oversampled levels. Each line passes through a two-flop synchronizer and a glitch filter, and the start and stop conditions are found on the filtered levels. The block drives the data line only by pulling it low, through `sda_pull`. Both write and read transfers move several bytes at once and step the register pointer after each byte. A read can name its register through a write phase followed by a repeated start, or it can open directly with a read header and continue from wherever the pointer was left.

Top module: `pmic_ctl_i2c`

## Requirements
- R1: After reset the register outputs read buck voltage 0 = 0x10, buck voltage 1 = 0x10, LDO voltage 0 = 0x0C, LDO voltage 1 = 0x0C, converter options = 0x0F, system control = 0x2F, slew = 0x22. The register pointer is 0 and `sda_pull` is low.
- R2: The block acknowledges a header byte only when its upper seven bits equal 7'b1101000. Bit 0 is the direction: 0 means write, 1 means read. Any other header is not acknowledged, and the transfer that follows changes no register.
- R3: In a write, the byte after the header loads the pointer. Each later data byte is acknowledged, stored at the pointer, and advances the pointer. Register 6 is followed by register 0.
- R4: Reserved bits cannot be written and always read as zero. The writable masks are 0x7F for registers 0 and 1, 0x3F for registers 2, 3 and 4, 0x7F for register 5, and 0xEE for register 6.
- R5: A register address above 6 is acknowledged. Data bytes sent to it are acknowledged and discarded, and the pointer stays where it is. Reads from that pointer return 0x00.
- R6: A write phase that carries only a register address, followed by a repeated start and a read header, returns data from that register onward. The pointer advances after each byte and wraps from 6 to 0.
- R7: A read that opens directly with a read header returns data starting at the current pointer, which is the position left by the previous transfer.
- R8: In a read, the block sends the next byte after each master acknowledge. After a master not-acknowledge it stops driving, and `sda_pull` stays low until the next start.
- R9: A pulse on either bus line shorter than FILT_LEN samples is ignored. It moves no bit and causes no start or stop.
- R10: `sda_pull` changes only after a falling edge of the filtered clock line, or on a start or stop. The data line is therefore steady while the clock line is high.
- R11: A stop or start that interrupts a byte discards the partial byte. No register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Sampled bus clock line |
| sda_in | input | 1 | Sampled bus data line |
| sda_pull | output | 1 | Pull the data line low when high |
| buck_v0 | output | 8 | Register 0, converter 0 voltage code |
| buck_v1 | output | 8 | Register 1, converter 1 voltage code |
| ldo_v0 | output | 8 | Register 2, regulator 0 voltage code |
| ldo_v1 | output | 8 | Register 3, regulator 1 voltage code |
| buck_opt | output | 8 | Register 4, converter options |
| sys_ctl | output | 8 | Register 5, enables and power-good delay |
| slew_ctl | output | 8 | Register 6, slew rate codes |

## Verification
A pointer that steps wrongly, or fails to wrap, shows up at the register outputs once the next data byte lands: the wrong bus changes. A current-pointer read exposes it on the very next byte. A wrong mask or reset value is visible on the parallel buses as soon as the write or the reset completes. A bit counter that slips because of a glitch, or a misplaced acknowledge, corrupts the byte that is being transferred. The bench sees this through the acknowledge bit it samples or through the stored value in the following cycles, and it also flags any change of `sda_pull` while the clock line is high.

// File: rtl/pmic_ctl_i2c.sv
module pmic_ctl_i2c #(
  parameter logic [6:0] DEV_ADDR = 7'b1101000,
  parameter int         FILT_LEN = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       sda_pull,
  output logic [7:0] buck_v0,
  output logic [7:0] buck_v1,
  output logic [7:0] ldo_v0,
  output logic [7:0] ldo_v1,
  output logic [7:0] buck_opt,
  output logic [7:0] sys_ctl,
  output logic [7:0] slew_ctl
);

  localparam int         NREG  = 7;
  localparam logic [7:0] PLAST = 8'(NREG - 1);
  localparam int         CW    = (FILT_LEN < 2) ? 1 : $clog2(FILT_LEN + 1);

  typedef enum logic [2:0] {ST_IDLE, ST_ADDR, ST_REG, ST_WR, ST_RD} st_t;

  function automatic logic [7:0] rst_val(input logic [2:0] i);
    case (i)
      3'd0, 3'd1: rst_val = 8'h10;
      3'd2, 3'd3: rst_val = 8'h0C;
      3'd4:       rst_val = 8'h0F;
      3'd5:       rst_val = 8'h2F;
      default:    rst_val = 8'h22;
    endcase
  endfunction

  function automatic logic [7:0] wmask(input logic [2:0] i);
    case (i)
      3'd0, 3'd1, 3'd5: wmask = 8'h7F;
      3'd2, 3'd3, 3'd4: wmask = 8'h3F;
      default:          wmask = 8'hEE;
    endcase
  endfunction

  function automatic logic [7:0] nxt_ptr(input logic [7:0] p);
    if (p == PLAST)     nxt_ptr = 8'h00;
    else if (p < PLAST) nxt_ptr = p + 8'h01;
    else                nxt_ptr = p;
  endfunction

  // line conditioning: index 1 = clock line, index 0 = data line
  logic [1:0] raw, s1, s2, flt, flt_q;
  logic [CW-1:0] fcnt [2];
  assign raw = {scl_in, sda_in};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1    <= 2'b11;
      s2    <= 2'b11;
      flt_q <= 2'b11;
    end else begin
      s1    <= raw;
      s2    <= s1;
      flt_q <= flt;
    end

  for (genvar g = 0; g < 2; g++) begin : g_filt
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        fcnt[g] <= '0;
        flt[g]  <= 1'b1;
      end else if (s2[g] == flt[g]) begin
        fcnt[g] <= '0;
      end else if (fcnt[g] == CW'(FILT_LEN - 1)) begin
        fcnt[g] <= '0;
        flt[g]  <= s2[g];
      end else begin
        fcnt[g] <= fcnt[g] + 1'b1;
      end
  end

  logic start_det, stop_det, scl_rise, scl_fall;
  assign start_det = flt[1] & flt_q[1] &  flt_q[0] & ~flt[0];
  assign stop_det  = flt[1] & flt_q[1] & ~flt_q[0] &  flt[0];
  assign scl_rise  =  flt[1] & ~flt_q[1];
  assign scl_fall  = ~flt[1] &  flt_q[1];

  st_t        state;
  logic [3:0] bitcnt;
  logic [7:0] sr, tx, ptr;
  logic       rw, mnack;
  logic [7:0] rf [NREG];
  logic [7:0] rd_byte;
  logic       wr_fire;

  assign rd_byte = (ptr <= PLAST) ? rf[ptr[2:0]] : 8'h00;
  assign wr_fire = (state == ST_WR) && scl_fall && (bitcnt == 4'd8) && (ptr <= PLAST);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state    <= ST_IDLE;
      bitcnt   <= '0;
      sr       <= '0;
      tx       <= '0;
      ptr      <= '0;
      rw       <= 1'b0;
      mnack    <= 1'b0;
      sda_pull <= 1'b0;
    end else if (start_det) begin
      state    <= ST_ADDR;
      bitcnt   <= '0;
      sda_pull <= 1'b0;
    end else if (stop_det) begin
      state    <= ST_IDLE;
      bitcnt   <= '0;
      sda_pull <= 1'b0;
    end else if (state != ST_IDLE) begin
      if (scl_rise) begin
        if (bitcnt < 4'd8) begin
          sr     <= {sr[6:0], flt[0]};
          bitcnt <= bitcnt + 4'd1;
        end else if (bitcnt == 4'd8) begin
          bitcnt <= 4'd9;
          mnack  <= flt[0];
        end
      end else if (scl_fall) begin
        if (bitcnt == 4'd8) begin
          case (state)
            ST_ADDR:
              if (sr[7:1] == DEV_ADDR) begin
                sda_pull <= 1'b1;
                rw       <= sr[0];
              end else begin
                state  <= ST_IDLE;
                bitcnt <= '0;
              end
            ST_REG: begin
              sda_pull <= 1'b1;
              ptr      <= sr;
            end
            ST_WR: begin
              sda_pull <= 1'b1;
              ptr      <= nxt_ptr(ptr);
            end
            default: sda_pull <= 1'b0;
          endcase
        end else if (bitcnt == 4'd9) begin
          bitcnt   <= '0;
          sda_pull <= 1'b0;
          case (state)
            ST_ADDR:
              if (rw) begin
                state    <= ST_RD;
                tx       <= {rd_byte[6:0], 1'b0};
                sda_pull <= ~rd_byte[7];
                ptr      <= nxt_ptr(ptr);
              end else begin
                state <= ST_REG;
              end
            ST_REG: state <= ST_WR;
            ST_RD:
              if (mnack) begin
                state <= ST_IDLE;
              end else begin
                tx       <= {rd_byte[6:0], 1'b0};
                sda_pull <= ~rd_byte[7];
                ptr      <= nxt_ptr(ptr);
              end
            default: ;
          endcase
        end else if (state == ST_RD && bitcnt != 4'd0) begin
          sda_pull <= ~tx[7];
          tx       <= {tx[6:0], 1'b0};
        end
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) rf[i] <= rst_val(3'(i));
    end else if (wr_fire) begin
      rf[ptr[2:0]] <= sr & wmask(ptr[2:0]);
    end

  assign buck_v0  = rf[0];
  assign buck_v1  = rf[1];
  assign ldo_v0   = rf[2];
  assign ldo_v1   = rf[3];
  assign buck_opt = rf[4];
  assign sys_ctl  = rf[5];
  assign slew_ctl = rf[6];

  logic [8*NREG-1:0] reg_vec;
  assign reg_vec = {buck_v0, buck_v1, ldo_v0, ldo_v1, buck_opt, sys_ctl, slew_ctl};

  // R3
  reg_write_only_on_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_fire |=> $stable(reg_vec));

  // R9
  scl_filter_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s2[1] == flt[1]) |=> $stable(flt[1]));

  // R10
  sda_change_at_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(scl_fall || start_det || stop_det) |=> $stable(sda_pull));

  // R11
  start_resets_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (state == ST_ADDR && bitcnt == 4'd0 && !sda_pull));

  // R8
  stop_releases_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (state == ST_IDLE && !sda_pull));

endmodule

// File: tb/pmic_ctl_i2c_test.sv
module pmic_ctl_i2c_test;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, scl_g = 1'b0, sda_g = 1'b0;
  logic sda_pull;
  logic [7:0] buck_v0, buck_v1, ldo_v0, ldo_v1, buck_opt, sys_ctl, slew_ctl;
  logic sda_line, scl_in, sda_in;

  always #5 clk = ~clk;

  assign sda_line = sda_m & ~sda_pull;
  assign scl_in   = scl_m | scl_g;
  assign sda_in   = sda_line & ~sda_g;

  pmic_ctl_i2c uut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in), .sda_pull(sda_pull),
    .buck_v0(buck_v0), .buck_v1(buck_v1), .ldo_v0(ldo_v0), .ldo_v1(ldo_v1),
    .buck_opt(buck_opt), .sys_ctl(sys_ctl), .slew_ctl(slew_ctl)
  );

  int nchk = 0, nerr = 0, hi_moves = 0;
  bit done = 0;
  logic [7:0] exp_r [7];
  int mptr = 0;

  function automatic logic [7:0] m_rst(input int i);
    case (i)
      0, 1: return 8'h10;
      2, 3: return 8'h0C;
      4: return 8'h0F;
      5: return 8'h2F;
      default: return 8'h22;
    endcase
  endfunction

  function automatic logic [7:0] m_mask(input int i);
    case (i)
      0, 1, 5: return 8'h7F;
      2, 3, 4: return 8'h3F;
      default: return 8'hEE;
    endcase
  endfunction

  function automatic logic [7:0] get_out(input int i);
    case (i)
      0: return buck_v0;
      1: return buck_v1;
      2: return ldo_v0;
      3: return ldo_v1;
      4: return buck_opt;
      5: return sys_ctl;
      default: return slew_ctl;
    endcase
  endfunction

  function automatic int m_next(input int p);
    if (p == 6) return 0;
    if (p < 6) return p + 1;
    return p;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wait_q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic xfer_bit(input logic b, input bit gl, output logic s);
    logic s0;
    wait_q();
    sda_m = b;
    if (gl) begin
      repeat (3) @(negedge clk);
      scl_g = 1'b1;
      @(negedge clk);
      scl_g = 1'b0;
      repeat (Q - 4) @(negedge clk);
    end else begin
      wait_q();
    end
    scl_m = 1'b1;
    repeat (2) @(negedge clk);
    s0 = sda_line;
    repeat (Q - 2) @(negedge clk);
    s = sda_line;
    if (gl && b) begin
      sda_g = 1'b1;
      @(negedge clk);
      sda_g = 1'b0;
      repeat (Q - 1) @(negedge clk);
    end else begin
      wait_q();
    end
    if (sda_line !== s0) hi_moves++;
    scl_m = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] d, input bit gl, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) xfer_bit(d[i], gl && (i == 3), s);
    xfer_bit(1'b1, 1'b0, ack);
  endtask

  task automatic recv_byte(input logic nack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      xfer_bit(1'b1, 1'b0, s);
      d[i] = s;
    end
    xfer_bit(nack, 1'b0, s);
  endtask

  task automatic bus_start();
    sda_m = 1'b1;
    wait_q();
    scl_m = 1'b1;
    wait_q();
    sda_m = 1'b0;
    wait_q();
    scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    wait_q();
    sda_m = 1'b0;
    wait_q();
    scl_m = 1'b1;
    wait_q();
    sda_m = 1'b1;
    wait_q();
  endtask

  task automatic check_all(input string tag);
    for (int i = 0; i < 7; i++) chk(tag, get_out(i), exp_r[i]);
  endtask

  task automatic do_write(input int a, input int n, input logic [7:0] first, input bit gl, input string tag);
    logic ack;
    logic [7:0] d;
    bus_start();
    send_byte(8'hD0, 1'b0, ack);
    chk("R2 header ack", {7'd0, ack}, 8'h00);
    send_byte(8'(a), 1'b0, ack);
    chk((a > 6) ? "R5 far address ack" : "R3 address ack", {7'd0, ack}, 8'h00);
    mptr = a;
    for (int k = 0; k < n; k++) begin
      d = (k == 0) ? first : 8'($urandom);
      send_byte(d, gl, ack);
      chk(tag, {7'd0, ack}, 8'h00);
      if (mptr <= 6) exp_r[mptr] = d & m_mask(mptr);
      mptr = m_next(mptr);
    end
    bus_stop();
    check_all(tag);
  endtask

  task automatic read_bytes(input int n, input string tag);
    logic [7:0] d;
    for (int k = 0; k < n; k++) begin
      recv_byte((k == n - 1), d);
      chk(tag, d, (mptr <= 6) ? exp_r[mptr] : 8'h00);
      mptr = m_next(mptr);
    end
    bus_stop();
    chk("R8 released after stop", {7'd0, sda_pull}, 8'h00);
  endtask

  task automatic do_read_comb(input int a, input int n);
    logic ack;
    bus_start();
    send_byte(8'hD0, 1'b0, ack);
    chk("R6 header ack", {7'd0, ack}, 8'h00);
    send_byte(8'(a), 1'b0, ack);
    chk("R6 address ack", {7'd0, ack}, 8'h00);
    mptr = a;
    bus_start();
    send_byte(8'hD1, 1'b0, ack);
    chk("R6 read header ack", {7'd0, ack}, 8'h00);
    read_bytes(n, "R6 read data");
  endtask

  task automatic do_read_cur(input int n);
    logic ack;
    bus_start();
    send_byte(8'hD1, 1'b0, ack);
    chk("R7 read header ack", {7'd0, ack}, 8'h00);
    read_bytes(n, "R7 current read data");
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic s;
    void'($urandom(32'd1234));
    for (int i = 0; i < 7; i++) exp_r[i] = m_rst(i);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check_all("R1 reset value");
    chk("R1 sda_pull idle", {7'd0, sda_pull}, 8'h00);

    // R2 foreign header: no ack, no effect
    bus_start();
    send_byte(8'hA0, 1'b0, ack);
    chk("R2 foreign header nack", {7'd0, ack}, 8'h01);
    send_byte(8'h01, 1'b0, ack);
    send_byte(8'h33, 1'b0, ack);
    bus_stop();
    check_all("R2 foreign transfer ignored");

    // R3 R4 wrap from 6 to 0 with full masks
    do_write(5, 3, 8'hFF, 1'b0, "R4 masked write");
    exp_r[6] = 8'hEE; exp_r[0] = 8'h7F;
    do_write(6, 2, 8'hFF, 1'b0, "R3 wrap write");
    chk("R4 slew reserved bits", slew_ctl, 8'hEE);
    chk("R3 wrap landed in reg 0", buck_v0, exp_r[0]);

    // R7 current-pointer read continues at 1
    do_read_cur(2);

    // R5 address beyond map
    do_write(9, 2, 8'h55, 1'b0, "R5 far data ack");
    do_read_cur(1);

    // R6 combined read wrapping
    do_read_comb(6, 3);

    // R9 glitches on both lines during a write
    do_write(3, 1, 8'h2A, 1'b1, "R9 glitch write");
    chk("R9 value survives glitches", ldo_v1, 8'h2A);

    // R11 stop in the middle of a byte
    bus_start();
    send_byte(8'hD0, 1'b0, ack);
    send_byte(8'h02, 1'b0, ack);
    mptr = 2;
    for (int i = 0; i < 4; i++) xfer_bit(1'b1, 1'b0, s);
    bus_stop();
    check_all("R11 partial byte discarded");
    do_read_cur(1);

    // random mix
    for (int op = 0; op < 24; op++) begin
      int kind = int'($urandom_range(0, 2));
      int n    = int'($urandom_range(1, 4));
      int a    = ($urandom_range(0, 7) == 0) ? int'($urandom_range(7, 255)) : int'($urandom_range(0, 6));
      case (kind)
        0: do_write(a, n, 8'($urandom), 1'b0, "R3 random write");
        1: do_read_comb(a, n);
        default: do_read_cur(n);
      endcase
    end

    chk("R10 data line steady while clock high", 8'(hi_moves), 8'h00);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
    $finish;
  end
endmodule